// File: doc/BRIEF.md
# Colour Palette Lookup with Byte-Wide Host Access

This block holds a 256-entry colour lookup table. Each entry is an 18-bit colour made of 6-bit red, green and blue fields. A host reaches the table through three byte registers: a write pointer, a read pointer and a data register. The read pointer shares its address with a status byte. Every entry takes three data accesses, one for each component. Each pointer has its own component counter, and the pointer moves to the next entry on its own once a triple is complete. The whole table can therefore be streamed in or out after a single pointer load.

A separate pixel port turns an 8-bit pixel index into the 18-bit colour stored for it. It has a fixed latency of one clock and does not interact with host traffic.

Top module: `pal_dac`

## Requirements
- R1: `host_addr` decodes as follows: 0 is the write pointer (read/write), 1 is the read pointer on writes and the status byte on reads, and 2 is the data register. Address 3 reads as 8'h00, and writes to it change nothing.
- R2: Writing address 0 loads the write pointer, returns the write component counter to red and puts the status into write mode. Reading address 0 returns the write pointer.
- R3: Writing address 1 loads the read pointer, returns the read component counter to red and puts the status into read mode.
- R4: Reading address 1 returns 8'h03 in write mode and 8'h00 in read mode.
- R5: Three data writes supply red, green and blue in that order, taking bits 5:0 and ignoring bits 7:6. The entry is written only on the blue access. Red and green wait in staging registers until then.
- R6: A data read returns the current component of the entry at the read pointer as {2'b00, value} in the same cycle. The order is red, then green, then blue, and the counter advances at the clock edge that ends the read.
- R7: When a triple completes, its pointer increments by one, wrapping from 255 to 0.
- R8: Data writes leave the read pointer and read counter unchanged. Data reads leave the write pointer and write counter unchanged.
- R9: One clock after `pix_idx` is presented, `pix_rgb` equals {R,G,B} of that entry (red in bits 17:12, blue in bits 5:0).
- R10: If `host_wr` and `host_rd` are high in the same cycle, only the write takes effect. The read advances no counter.
- R11: After reset, both pointers are 0, both counters are at red, and the status reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (combinational) |
| pix_idx | input | 8 | Pixel index |
| pix_rgb | output | 18 | Colour for the index presented one clock earlier |

## Verification
A corrupted component counter shows up on the very next data access: it returns the wrong component, or it writes into the wrong staging slot. The pixel port exposes a wrong staging slot one clock after the blue write. A pointer that steps at the wrong time, or fails to step, shows up at once in a readback of address 0. For the read side, the entry returned after the next triple is wrong. A status flag that has flipped is visible on the next read of address 1. The bench follows every access with a reference model, so the first wrong byte gets flagged in the cycle it appears.

// File: rtl/pal_dac.sv
module pal_dac #(
  parameter int IDX_W = 8,
  parameter int CW    = 6,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [3*CW-1:0]   pix_rgb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int EW    = 3 * CW;
  localparam logic [1:0] A_WIDX = 2'd0, A_RIDX = 2'd1, A_DATA = 2'd2;

  logic [EW-1:0]    pal [DEPTH];
  logic [IDX_W-1:0] widx, ridx;
  logic [1:0]       wcnt, rcnt;
  logic             wmode;
  logic [CW-1:0]    stg_r, stg_g, rcomp;

  wire ld_widx = host_wr && host_addr == A_WIDX;
  wire ld_ridx = host_wr && host_addr == A_RIDX;
  wire wr_data = host_wr && host_addr == A_DATA;
  wire rd_data = host_rd && !host_wr && host_addr == A_DATA;
  wire w_last  = wr_data && wcnt == 2'd2;
  wire r_last  = rd_data && rcnt == 2'd2;
  wire [EW-1:0] rentry = pal[ridx];

  always_comb begin
    case (rcnt)
      2'd0:    rcomp = rentry[EW-1:2*CW];
      2'd1:    rcomp = rentry[2*CW-1:CW];
      default: rcomp = rentry[CW-1:0];
    endcase
  end

  always_comb begin
    case (host_addr)
      A_WIDX:  host_rdata = DW'(widx);
      A_RIDX:  host_rdata = DW'({wmode, wmode});
      A_DATA:  host_rdata = DW'(rcomp);
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx  <= '0;
      ridx  <= '0;
      wcnt  <= 2'd0;
      rcnt  <= 2'd0;
      wmode <= 1'b0;
      stg_r <= '0;
      stg_g <= '0;
    end else begin
      if (ld_widx) begin
        widx  <= host_wdata[IDX_W-1:0];
        wcnt  <= 2'd0;
        wmode <= 1'b1;
      end else if (wr_data) begin
        if (wcnt == 2'd0) stg_r <= host_wdata[CW-1:0];
        if (wcnt == 2'd1) stg_g <= host_wdata[CW-1:0];
        wcnt <= w_last ? 2'd0 : wcnt + 2'd1;
        if (w_last) widx <= widx + 1'b1;
      end
      if (ld_ridx) begin
        ridx  <= host_wdata[IDX_W-1:0];
        rcnt  <= 2'd0;
        wmode <= 1'b0;
      end else if (rd_data) begin
        rcnt <= r_last ? 2'd0 : rcnt + 2'd1;
        if (r_last) ridx <= ridx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (w_last) pal[widx] <= {stg_r, stg_g, host_wdata[CW-1:0]};
    pix_rgb <= pal[pix_idx];
  end
endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
  parameter int IDX_W = 8,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic             host_rd,
  input logic [1:0]       host_addr,
  input logic [DW-1:0]    host_wdata,
  input logic [DW-1:0]    host_rdata,
  input logic [IDX_W-1:0] widx,
  input logic [IDX_W-1:0] ridx,
  input logic [1:0]       wcnt,
  input logic [1:0]       rcnt
);
  wire wr_d = host_wr && host_addr == 2'd2;
  wire rd_d = host_rd && !host_wr && host_addr == 2'd2;

  assert_widx_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0) |=> (widx == $past(host_wdata[IDX_W-1:0]) && wcnt == 2'd0));
  assert_ridx_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd1) |=> (ridx == $past(host_wdata[IDX_W-1:0]) && rcnt == 2'd0));
  assert_status_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd1) |-> (host_rdata == 8'h03 || host_rdata == 8'h00));
  assert_count_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt != 2'd3 && rcnt != 2'd3));
  assert_data_pad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd2) |-> host_rdata[DW-1:DW-2] == 2'b00);
  assert_wptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && wcnt == 2'd2) |=> widx == $past(widx) + 1'b1);
  assert_rptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_d && !host_rd) |=> ($stable(ridx) && $stable(rcnt)));
  assert_both_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_rd && host_addr == 2'd2) |=> ($stable(rcnt) && $stable(ridx)));
  assert_addr3_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 2'd3 && !rd_d) |=> ($stable(widx) && $stable(ridx) && $stable(wcnt)));
endmodule

bind pal_dac pal_dac_chk #(.IDX_W(IDX_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .widx(widx), .ridx(ridx), .wcnt(wcnt), .rcnt(rcnt)
);

// File: tb/pal_dac_tb.sv
`timescale 1ns/1ps
module pal_dac_tb;
  logic clk = 0, rst_n = 0, host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_rdata, pix_idx = 0;
  logic [17:0] pix_rgb;
  int checks = 0, fails = 0;

  logic [17:0] m_pal [256];
  logic [7:0] m_widx = 0, m_ridx = 0;
  int m_wcnt = 0, m_rcnt = 0;
  logic m_wmode = 0;
  logic [5:0] m_r = 0, m_g = 0;

  always #2.5 clk = ~clk;

  pal_dac u_dut (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb));

  function automatic logic [7:0] comp(logic [17:0] e, int c);
    return c == 0 ? {2'b00, e[17:12]} : c == 1 ? {2'b00, e[11:6]} : {2'b00, e[5:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_wr(logic [1:0] a, logic [7:0] d);
    case (a)
      2'd0: begin m_widx = d; m_wcnt = 0; m_wmode = 1; end
      2'd1: begin m_ridx = d; m_rcnt = 0; m_wmode = 0; end
      2'd2: begin
        if (m_wcnt == 0) m_r = d[5:0];
        else if (m_wcnt == 1) m_g = d[5:0];
        else begin m_pal[m_widx] = {m_r, m_g, d[5:0]}; m_widx++; end
        m_wcnt = (m_wcnt + 1) % 3;
      end
      default: ;
    endcase
  endtask

  function automatic logic [7:0] model_rd(logic [1:0] a);
    case (a)
      2'd0: return m_widx;
      2'd1: return m_wmode ? 8'h03 : 8'h00;
      2'd2: return comp(m_pal[m_ridx], m_rcnt);
      default: return 8'h00;
    endcase
  endfunction

  task automatic hwrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk); host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 0;
    model_wr(a, d);
  endtask

  task automatic hread(logic [1:0] a, string req);
    @(negedge clk); host_rd = 1; host_addr = a; #1;
    chk(req, host_rdata, model_rd(a));
    @(negedge clk); host_rd = 0;
    if (a == 2'd2) begin
      if (m_rcnt == 2) m_ridx++;
      m_rcnt = (m_rcnt + 1) % 3;
    end
  endtask

  task automatic pix(logic [7:0] i, string req);
    @(negedge clk); pix_idx = i;
    @(negedge clk); chk(req, pix_rgb, m_pal[i]);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    hread(2'd1, "R11 status"); hread(2'd0, "R11 widx");
    hread(2'd3, "R1 addr3");
    hwrite(2'd0, 8'h00); hread(2'd1, "R4 write mode");
    for (int i = 0; i < 768; i++) hwrite(2'd2, 8'($urandom));
    hread(2'd0, "R7 wrap widx");
    hwrite(2'd1, 8'h00); hread(2'd1, "R4 read mode");
    for (int i = 0; i < 768; i++) hread(2'd2, "R6 stream read");
    for (int i = 0; i < 16; i++) pix(8'($urandom), "R9 pixel");
    // R5 partial write leaves entry untouched
    hwrite(2'd0, 8'd5); hwrite(2'd2, 8'hFF); hwrite(2'd2, 8'hC1);
    pix(8'd5, "R5 no commit before blue");
    hwrite(2'd1, 8'd5); hread(2'd2, "R5 old red");
    hwrite(2'd2, 8'hE7); pix(8'd5, "R5 commit on blue");
    hread(2'd2, "R8 read order kept across writes");
    hread(2'd2, "R8 blue");
    hread(2'd0, "R2 widx after triple");
    // R7 wrap at 255
    hwrite(2'd0, 8'hFF); hwrite(2'd2, 8'h11); hwrite(2'd2, 8'h22); hwrite(2'd2, 8'h33);
    hread(2'd0, "R7 wrap 255->0"); pix(8'hFF, "R7 entry 255");
    // R10 both strobes
    hwrite(2'd1, 8'd9);
    @(negedge clk); host_wr = 1; host_rd = 1; host_addr = 2'd2; host_wdata = 8'h2A;
    @(negedge clk); host_wr = 0; host_rd = 0; model_wr(2'd2, 8'h2A);
    hread(2'd2, "R10 read unaffected");
    hwrite(2'd3, 8'h77); hread(2'd0, "R1 addr3 write ignored");
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 8);
      case (op)
        0: hwrite(2'd0, 8'($urandom));
        1: hwrite(2'd1, 8'($urandom));
        2, 3: hwrite(2'd2, 8'($urandom));
        4, 5: hread(2'd2, "R6 random data read");
        6: hread(2'd0, "R2 random widx read");
        7: hread(2'd1, "R4 random status");
        default: begin hwrite(2'd3, 8'($urandom)); pix(8'($urandom), "R9 random pixel"); end
      endcase
    end
    rst_n = 0; @(negedge clk); rst_n = 1;
    m_widx = 0; m_ridx = 0; m_wcnt = 0; m_rcnt = 0; m_wmode = 0;
    hread(2'd1, "R11 status after reset"); hread(2'd0, "R11 widx after reset");
    hread(2'd2, "R11 read counter at red");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule